// File: doc/BRIEF.md
# Byte-Wide Host to 16-Bit IDE Programmed-I/O Bridge

This bridge lets a small 8-bit host bus run a legacy IDE/ATA drive at the slowest programmed-I/O timing. The host sees four byte locations. One sets the target device register (bank and 3-bit address). One starts a device access. One reaches a byte latch for the upper half of 16-bit data words. One holds a device-reset control bit and a busy flag.

Each device access is a fixed sequence with three phases. Address and chip select are set up first. The read or write strobe is then held low. A hold phase follows before the address is released. The phase lengths are parameters. Sector data moves as 16-bit words in two host byte accesses. On a read, the upper byte is captured into the latch in the same strobe. On a write, the latch is preloaded and then sent together with the low byte. Command and status registers use only the low byte. All device-side control lines are registered and idle high, so neither bridge reset nor a bus turnaround can pulse them. The device interrupt is synchronised and passed to the host as an active-low line.

Top module: `ide_pio_bridge`

## Requirements
- R1: After reset, the chip selects, read strobe, write strobe and device reset are all high. dd_oe is low, h_wait is low and h_irq_n is high.
- R2: Host location 0 holds the target register. Bit 3 selects the bank (0 gives dcs0_n low, 1 gives dcs1_n low) and bits 2:0 give da. A read of location 0 returns these 4 bits with the upper bits zero. At most one chip select is ever low.
- R3: A device access keeps a chip select low for T_SETUP clocks with both strobes high. The strobe is then low for T_STROBE clocks. The chip select stays low for T_HOLD further clocks with both strobes high. A strobe is never low without a chip select, and both strobes are never low at once.
- R4: A read of host location 1 starts a device read. The host receives the low byte of the device word. When bank 0 register 0 is selected, the upper byte is captured into the latch, and location 2 then returns it.
- R5: A write to location 2 loads the latch. A later write to location 1 with bank 0 register 0 selected drives {latch, byte} onto dd_out during one write strobe. dd_oe is high whenever diow_n is low.
- R6: For any other selected register, a write to location 1 drives the upper byte as zero, and a read leaves the latch unchanged.
- R7: dd_oe is high only inside write accesses. It is never high while dior_n is low, and it changes only in cycles where both strobes were high and stay high.
- R8: h_wait is low when no host access is requested. It is high from the request of a location-1 access until the cycle the access ends (T_SETUP+T_STROBE+T_HOLD+1 cycles). Accesses to locations 0 and 2 that arrive while idle complete without wait.
- R9: Bit 0 of location 3 holds drst_n low while set. Any fall of drst_n follows a host write of 1 to that bit. A read of location 3 returns the busy flag in bit 7 and the reset bit in bit 0.
- R10: A high dirq drives h_irq_n low after two clocks, and a low dirq returns it high. An undriven dirq is read as low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_addr | input | 2 | Host location select |
| h_wdata | input | 8 | Host write byte |
| h_rd | input | 1 | Host read request, held until h_wait is low |
| h_wr | input | 1 | Host write request, held until h_wait is low |
| h_rdata | output | 8 | Host read byte |
| h_wait | output | 1 | Stall for the current host access |
| h_irq_n | output | 1 | Active-low interrupt to host |
| dd_in | input | 16 | Device data bus, inbound |
| dd_out | output | 16 | Device data bus, outbound |
| dd_oe | output | 1 | Tri-state enable for dd_out |
| da | output | 3 | Device register address |
| dcs0_n | output | 1 | Device chip select, bank 0, active low |
| dcs1_n | output | 1 | Device chip select, bank 1, active low |
| dior_n | output | 1 | Device read strobe, active low |
| diow_n | output | 1 | Device write strobe, active low |
| drst_n | output | 1 | Device reset, active low |
| dirq | input | 1 | Device interrupt, active high |

## Verification
The bench builds the bridge with T_SETUP=3, T_STROBE=4 and T_HOLD=2. The defaults are sized for mode-0 timing at this clock. With these short, distinct phases, each phase length can be counted separately at the device pins, and many accesses fit in a short run. The expected stall of ten cycles for a data access follows directly from the three values.

// File: rtl/ide_bridge_pkg.sv
package ide_bridge_pkg;
  localparam logic [1:0] LOC_SEL  = 2'd0;
  localparam logic [1:0] LOC_DATA = 2'd1;
  localparam logic [1:0] LOC_HIGH = 2'd2;
  localparam logic [1:0] LOC_CTRL = 2'd3;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD, PH_DONE
  } phase_e;
endpackage

// File: rtl/ide_irq_sync.sv
module ide_irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_in,
  output logic irq_out_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], irq_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign irq_out_n = ~sync_q[STAGES-1];
endmodule

// File: rtl/ide_pio_seq.sv
module ide_pio_seq
  import ide_bridge_pkg::*;
#(
  parameter int T_SETUP  = 14,
  parameter int T_STROBE = 58,
  parameter int T_HOLD   = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        is_write,
  input  logic        cs_bank,
  input  logic [2:0]  reg_addr,
  input  logic [15:0] wr_word,
  output logic        busy,
  output logic        done,
  output logic        capture,
  output logic [2:0]  da,
  output logic        dcs0_n,
  output logic        dcs1_n,
  output logic        dior_n,
  output logic        diow_n,
  output logic        dd_oe,
  output logic [15:0] dd_out
);
  localparam int TMAX1 = (T_SETUP > T_STROBE) ? T_SETUP : T_STROBE;
  localparam int TMAX  = (TMAX1 > T_HOLD) ? TMAX1 : T_HOLD;
  localparam int CW    = $clog2(TMAX + 1);

  phase_e        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          wr_q, bank_q;
  logic [2:0]    addr_q;
  logic [15:0]   word_q;
  logic          launch, wr_nx, bank_nx, act_nx;
  logic [2:0]    addr_nx;
  logic [2:0]    da_d;
  logic          cs0_d, cs1_d, rd_d, wrs_d, oe_d;

  assign launch = (ph_q == PH_IDLE) && start;

  // phase sequencing
  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    unique case (ph_q)
      PH_IDLE: if (start) begin
        ph_d  = PH_SETUP;
        cnt_d = CW'(T_SETUP - 1);
      end
      PH_SETUP: if (cnt_q == '0) begin
        ph_d  = PH_STROBE;
        cnt_d = CW'(T_STROBE - 1);
      end else cnt_d = cnt_q - 1'b1;
      PH_STROBE: if (cnt_q == '0) begin
        ph_d  = PH_HOLD;
        cnt_d = CW'(T_HOLD - 1);
      end else cnt_d = cnt_q - 1'b1;
      PH_HOLD: if (cnt_q == '0) ph_d = PH_DONE;
               else cnt_d = cnt_q - 1'b1;
      default: ph_d = PH_IDLE;
    endcase
  end

  // decode device pins from the upcoming phase so outputs leave flops
  always_comb begin
    wr_nx   = launch ? is_write : wr_q;
    bank_nx = launch ? cs_bank  : bank_q;
    addr_nx = launch ? reg_addr : addr_q;
    act_nx  = (ph_d == PH_SETUP) || (ph_d == PH_STROBE) || (ph_d == PH_HOLD);
    cs0_d   = ~(act_nx && !bank_nx);
    cs1_d   = ~(act_nx && bank_nx);
    da_d    = act_nx ? addr_nx : 3'd0;
    rd_d    = ~((ph_d == PH_STROBE) && !wr_nx);
    wrs_d   = ~((ph_d == PH_STROBE) && wr_nx);
    oe_d    = act_nx && wr_nx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      dcs0_n <= 1'b1;
      dcs1_n <= 1'b1;
      dior_n <= 1'b1;
      diow_n <= 1'b1;
      dd_oe  <= 1'b0;
      da     <= 3'd0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      dcs0_n <= cs0_d;
      dcs1_n <= cs1_d;
      dior_n <= rd_d;
      diow_n <= wrs_d;
      dd_oe  <= oe_d;
      da     <= da_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q   <= 1'b0;
      bank_q <= 1'b0;
      addr_q <= 3'd0;
      word_q <= '0;
    end else if (launch) begin
      wr_q   <= is_write;
      bank_q <= cs_bank;
      addr_q <= reg_addr;
      word_q <= wr_word;
    end
  end

  assign dd_out  = word_q;
  assign busy    = (ph_q != PH_IDLE);
  assign done    = (ph_q == PH_DONE);
  assign capture = (ph_q == PH_STROBE) && (cnt_q == '0) && !wr_q;
endmodule

// File: rtl/ide_host_win.sv
module ide_host_win
  import ide_bridge_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  h_addr,
  input  logic [7:0]  h_wdata,
  input  logic        h_rd,
  input  logic        h_wr,
  output logic [7:0]  h_rdata,
  output logic        h_wait,
  input  logic        seq_busy,
  input  logic        seq_done,
  input  logic        seq_capture,
  input  logic [15:0] dd_in,
  output logic        start,
  output logic        is_write,
  output logic        cs_bank,
  output logic [2:0]  reg_addr,
  output logic [15:0] wr_word,
  output logic        dev_rst
);
  logic [3:0] sel_q, sel_d;
  logic [7:0] hi_q, hi_d;
  logic [7:0] lo_q, lo_d;
  logic       rst_q, rst_d;
  logic       req, is_dat, commit, word_sel;

  assign req      = h_rd | h_wr;
  assign is_dat   = (h_addr == LOC_DATA);
  assign word_sel = (sel_q == 4'd0);
  assign h_wait   = req && (is_dat ? !seq_done : ((h_addr != LOC_CTRL) && seq_busy));
  assign commit   = h_wr && !h_wait;
  assign start    = req && is_dat && !seq_busy;
  assign is_write = h_wr;
  assign cs_bank  = sel_q[3];
  assign reg_addr = sel_q[2:0];
  assign wr_word  = word_sel ? {hi_q, h_wdata} : {8'h00, h_wdata};
  assign dev_rst  = rst_q;

  always_comb begin
    sel_d = sel_q;
    hi_d  = hi_q;
    lo_d  = lo_q;
    rst_d = rst_q;
    if (commit && (h_addr == LOC_SEL))  sel_d = h_wdata[3:0];
    if (commit && (h_addr == LOC_CTRL)) rst_d = h_wdata[0];
    if (commit && (h_addr == LOC_HIGH)) hi_d  = h_wdata;
    else if (seq_capture && word_sel)   hi_d  = dd_in[15:8];
    if (seq_capture)                    lo_d  = dd_in[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      hi_q  <= '0;
      lo_q  <= '0;
      rst_q <= 1'b0;
    end else begin
      sel_q <= sel_d;
      hi_q  <= hi_d;
      lo_q  <= lo_d;
      rst_q <= rst_d;
    end
  end

  always_comb begin
    unique case (h_addr)
      LOC_SEL:  h_rdata = {4'd0, sel_q};
      LOC_DATA: h_rdata = lo_q;
      LOC_HIGH: h_rdata = hi_q;
      default:  h_rdata = {seq_busy, 6'd0, rst_q};
    endcase
  end
endmodule

// File: rtl/ide_pio_bridge.sv
module ide_pio_bridge #(
  parameter int T_SETUP  = 14,
  parameter int T_STROBE = 58,
  parameter int T_HOLD   = 6,
  parameter int IRQ_SYNC = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  h_addr,
  input  logic [7:0]  h_wdata,
  input  logic        h_rd,
  input  logic        h_wr,
  output logic [7:0]  h_rdata,
  output logic        h_wait,
  output logic        h_irq_n,
  input  logic [15:0] dd_in,
  output logic [15:0] dd_out,
  output logic        dd_oe,
  output logic [2:0]  da,
  output logic        dcs0_n,
  output logic        dcs1_n,
  output logic        dior_n,
  output logic        diow_n,
  output logic        drst_n,
  input  logic        dirq
);
  logic [1:0]  rsync_q;
  logic        srst_n;
  logic        seq_busy, seq_done, seq_capture;
  logic        start, is_write, cs_bank, dev_rst;
  logic [2:0]  reg_addr;
  logic [15:0] wr_word;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  ide_host_win i_win (
    .clk(clk), .rst_n(srst_n),
    .h_addr(h_addr), .h_wdata(h_wdata), .h_rd(h_rd), .h_wr(h_wr),
    .h_rdata(h_rdata), .h_wait(h_wait),
    .seq_busy(seq_busy), .seq_done(seq_done), .seq_capture(seq_capture),
    .dd_in(dd_in),
    .start(start), .is_write(is_write), .cs_bank(cs_bank),
    .reg_addr(reg_addr), .wr_word(wr_word), .dev_rst(dev_rst)
  );

  ide_pio_seq #(.T_SETUP(T_SETUP), .T_STROBE(T_STROBE), .T_HOLD(T_HOLD)) i_seq (
    .clk(clk), .rst_n(srst_n),
    .start(start), .is_write(is_write), .cs_bank(cs_bank),
    .reg_addr(reg_addr), .wr_word(wr_word),
    .busy(seq_busy), .done(seq_done), .capture(seq_capture),
    .da(da), .dcs0_n(dcs0_n), .dcs1_n(dcs1_n),
    .dior_n(dior_n), .diow_n(diow_n), .dd_oe(dd_oe), .dd_out(dd_out)
  );

  ide_irq_sync #(.STAGES(IRQ_SYNC)) i_irq (
    .clk(clk), .rst_n(srst_n), .irq_in(dirq), .irq_out_n(h_irq_n)
  );

  assign drst_n = ~dev_rst;
endmodule

// File: rtl/ide_pio_bridge_chk.sv
module ide_pio_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  h_addr,
  input logic [7:0]  h_wdata,
  input logic        h_rd,
  input logic        h_wr,
  input logic        h_wait,
  input logic        dd_oe,
  input logic        dcs0_n,
  input logic        dcs1_n,
  input logic        dior_n,
  input logic        diow_n,
  input logic        drst_n
);
  // R2
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~{dcs1_n, dcs0_n}));

  // R3
  strobe_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!dior_n || !diow_n) |-> !(dcs0_n && dcs1_n));

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dior_n || diow_n);

  // R5
  oe_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !diow_n |-> dd_oe);

  // R7
  oe_off_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dior_n |-> !dd_oe);

  // R7
  oe_turn_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dd_oe) |-> (dior_n && diow_n && $past(dior_n) && $past(diow_n)));

  // R8
  wait_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(h_rd || h_wr) |-> !h_wait);

  // R9
  dev_rst_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(drst_n) |-> $past(h_wr && (h_addr == 2'd3) && h_wdata[0]));
endmodule

bind ide_pio_bridge ide_pio_bridge_chk i_chk (
  .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_wdata(h_wdata),
  .h_rd(h_rd), .h_wr(h_wr), .h_wait(h_wait), .dd_oe(dd_oe),
  .dcs0_n(dcs0_n), .dcs1_n(dcs1_n), .dior_n(dior_n), .diow_n(diow_n),
  .drst_n(drst_n)
);

// File: tb/test_ide_pio_bridge.sv
`timescale 1ns/1ps
module test_ide_pio_bridge;
  localparam int TS = 3, TB = 4, TH = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  h_addr = 2'd0;
  logic [7:0]  h_wdata = 8'd0;
  logic        h_rd = 1'b0, h_wr = 1'b0;
  logic [7:0]  h_rdata;
  logic        h_wait, h_irq_n, dd_oe, dcs0_n, dcs1_n, dior_n, diow_n, drst_n;
  logic        dirq = 1'b0;
  logic [15:0] dd_in, dd_out, dev_word = 16'h0;
  logic [2:0]  da;

  int checks = 0, errors = 0, waits;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  // tracker of the last device access seen on the pins
  int ph_set = 0, ph_stb = 0, ph_hld = 0, last_set = 0, last_stb = 0, last_hld = 0;
  bit seen_stb = 0, oe_bad = 0;
  logic [15:0] last_word = 16'h0;
  logic [2:0]  last_da = 3'd0;
  logic [1:0]  last_cs = 2'b11;

  always #2.5 clk = ~clk;
  assign dd_in = dior_n ? 16'h0000 : dev_word;

  ide_pio_bridge #(.T_SETUP(TS), .T_STROBE(TB), .T_HOLD(TH)) i_ide_pio_bridge (
    .clk(clk), .rst_n(rst_n), .h_addr(h_addr), .h_wdata(h_wdata), .h_rd(h_rd),
    .h_wr(h_wr), .h_rdata(h_rdata), .h_wait(h_wait), .h_irq_n(h_irq_n),
    .dd_in(dd_in), .dd_out(dd_out), .dd_oe(dd_oe), .da(da), .dcs0_n(dcs0_n),
    .dcs1_n(dcs1_n), .dior_n(dior_n), .diow_n(diow_n), .drst_n(drst_n), .dirq(dirq)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic host_acc(bit wr, logic [1:0] a, logic [7:0] d, output int nw);
    nw = 0;
    @(negedge clk);
    h_addr = a; h_wdata = d; h_wr = wr; h_rd = !wr;
    #1;
    while (h_wait) begin nw++; @(negedge clk); #1; end
    @(negedge clk);
    h_wr = 1'b0; h_rd = 1'b0;
  endtask

  task automatic host_wr(logic [1:0] a, logic [7:0] d);
    int nw;
    host_acc(1'b1, a, d, nw);
    waits = nw;
  endtask

  task automatic host_rd(logic [1:0] a, logic [7:0] exp, string tag);
    int nw;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    host_acc(1'b0, a, 8'h00, nw);
    waits = nw;
  endtask

  // scoreboard monitor: compares each completed host read
  always @(negedge clk) begin
    #2;
    if (h_rd && !h_wait) begin
      if (exp_q.size() == 0) chk("R4", 1, 0);
      else chk(tag_q.pop_front(), int'(h_rdata), int'(exp_q.pop_front()));
    end
  end

  always @(negedge clk) begin
    #2;
    if (!dcs0_n || !dcs1_n) begin
      last_da = da;
      last_cs = {dcs1_n, dcs0_n};
      if (!dior_n || !diow_n) begin
        ph_stb++; seen_stb = 1;
        if (!diow_n) last_word = dd_out;
        if (!dior_n && dd_oe) oe_bad = 1;
      end else if (!seen_stb) ph_set++;
      else ph_hld++;
    end else if (ph_set != 0) begin
      last_set = ph_set; last_stb = ph_stb; last_hld = ph_hld;
      ph_set = 0; ph_stb = 0; ph_hld = 0; seen_stb = 0;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog actual=hung expected=complete");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    // R1 reset state
    chk("R1", {dcs1_n, dcs0_n, dior_n, diow_n, drst_n}, 5'b11111);
    chk("R1", {dd_oe, h_wait, h_irq_n}, 3'b001);

    // R2 select bank 0 register 0, read it back, no wait
    host_wr(2'd0, 8'h00);
    chk("R8", waits, 0);
    host_rd(2'd0, 8'h00, "R2");

    // R4 data word read
    dev_word = 16'hBEEF;
    host_rd(2'd1, 8'hEF, "R4");
    chk("R8", waits, TS + TB + TH + 1);
    @(negedge clk); #2;
    chk("R3", last_set, TS);
    chk("R3", last_stb, TB);
    chk("R3", last_hld, TH);
    chk("R2", {last_cs, last_da}, {2'b10, 3'd0});
    host_rd(2'd2, 8'hBE, "R4");

    // R5 latched high byte plus low byte in one write strobe
    host_wr(2'd2, 8'h12);
    chk("R8", waits, 0);
    host_wr(2'd1, 8'h34);
    @(negedge clk); #2;
    chk("R5", last_word, 16'h1234);
    chk("R3", last_stb, TB);
    chk("R7", dd_oe, 0);

    // R6 bank 1 register 6: low byte only, latch untouched
    host_wr(2'd0, 8'h0E);
    host_rd(2'd0, 8'h0E, "R2");
    host_wr(2'd1, 8'h55);
    @(negedge clk); #2;
    chk("R6", last_word, 16'h0055);
    chk("R2", {last_cs, last_da}, {2'b01, 3'd6});
    dev_word = 16'hA5C3;
    host_rd(2'd1, 8'hC3, "R6");
    host_rd(2'd2, 8'h12, "R6");
    chk("R7", oe_bad, 0);

    // R9 device reset control
    host_wr(2'd3, 8'h01);
    chk("R9", drst_n, 0);
    host_rd(2'd3, 8'h01, "R9");
    host_wr(2'd3, 8'h00);
    chk("R9", drst_n, 1);
    host_rd(2'd3, 8'h00, "R9");

    // R10 interrupt conditioning
    @(negedge clk); dirq = 1'b1;
    @(negedge clk); #2;
    chk("R10", h_irq_n, 1);
    repeat (2) @(negedge clk); #2;
    chk("R10", h_irq_n, 0);
    @(negedge clk); dirq = 1'b0;
    repeat (3) @(negedge clk); #2;
    chk("R10", h_irq_n, 1);

    chk("R4", exp_q.size(), 0);
    finish_run();
  end
endmodule